// File: doc/BRIEF.md
# Serial NOR Flash Command Engine

This block is the command layer of a serial NOR flash slave. An SPI shifter in front of it hands over one received byte per `rx_valid` strobe, and the block returns one response byte for each strobe on `tx_byte`. The active-low `cs_n` frames each command. The first byte of a frame is an opcode. The engine then gathers the address, and after that it streams reads, takes program data, or fires an erase against a small internal byte array.

Status and identification reads return their bytes from a short response buffer. A write-enable latch guards every change to the array. A per-instance capability mask decides which of the two sub-sector erase sizes are legal. A write-one option turns programming from bit-clearing into plain overwrite, so that the same command set can stand in for an EEPROM. The sizes of the device, the sector and both sub-sector erases are parameters. All of them are powers of two, and the device is at most 16 MiB.

Top module: `nor_flash_engine`

## Requirements
- R1: After reset every array byte reads 0xFF, `tx_byte` is 0x00, `cap_err` is 0 and the write-enable latch is clear.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Opcode 0x05 answers on the following strobe with one byte whose bit 1 is the latch and whose other bits are 0.
- R3: Opcode 0x03 takes three address bytes, most significant first, and only the low log2(device size) bits are used. Each following strobe returns the byte at the current address and then advances the address, wrapping from the last byte to byte 0.
- R4: Opcode 0x0B behaves like 0x03 but takes a fourth byte after the address, and the value of that byte is ignored.
- R5: After opcode 0x02 and three address bytes, each data byte is ANDed into the addressed byte when WRITE_ONE=0, or replaces it when WRITE_ONE=1. The address advances and wraps after each byte.
- R6: Program data has no effect on the array while the write-enable latch is clear.
- R7: Opcodes 0x20, 0x52 and 0xD8, each followed by three address bytes, fill with 0xFF the aligned region of ERASE_SMALL_BYTES, ERASE_MID_BYTES or SECTOR_BYTES that holds the address. Nothing changes while the latch is clear.
- R8: A 0x20 erase on an instance with CAP_SMALL=0, or a 0x52 erase on one with CAP_MID=0, leaves the array unchanged and sets `cap_err`. The flag then stays set until reset, whatever the state of the latch.
- R9: Opcode 0xC7 fills the whole array with 0xFF when the latch is set, and is ignored otherwise.
- R10: Opcode 0x9F returns the three identification bytes, most significant first. When EXT_ID is nonzero, its high byte and then its low byte follow. The byte after the last one is decoded as a new opcode.
- R11: While `cs_n` is high, strobes are ignored. A new frame always starts in opcode decode, even if the previous frame ended part way through a command.
- R12: `tx_byte` is 0x00 after every strobe that returns no data. This covers opcodes, address and dummy bytes, program data, opcode 0x00 and unknown opcodes, and the last two have no other effect.
- R13: `tx_byte` changes only at a clock edge where `rx_valid` is high and `cs_n` is low, and it holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Byte received from the shifter |
| tx_byte | output | 8 | Response byte for the most recent strobe |
| cap_err | output | 1 | Sticky flag: an erase size the instance lacks was requested |

## Verification
A wrong state or a miscounted address byte shows up on the very next strobe. An opcode that is taken as an address shifts every later read, and a stuck latch is visible in the next status byte. Errors in the array itself, such as a wrong erase alignment, a program that sets bits, or a missing wrap, stay hidden until the affected bytes are read back. For that reason the bench compares the whole array with a reference model after each random phase. A second instance with the write-one option on, no sub-sector capability and no extended ID receives the same byte stream, so both variants of each parameter are compared side by side.

// File: rtl/nor_pkg.sv
// Shared definitions for the serial NOR command engine: engine states,
// opcode values and erase region kinds. Assumes byte-wide transfers.
package nor_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PROG,
        ST_READ,
        ST_RESP
    } eng_state_t;

    typedef enum logic [1:0] {
        ER_SMALL,
        ER_MID,
        ER_SECT,
        ER_ALL
    } er_kind_t;

    localparam logic [7:0] OP_NOP    = 8'h00;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_WRDIS  = 8'h04;
    localparam logic [7:0] OP_STAT   = 8'h05;
    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_FREAD  = 8'h0B;
    localparam logic [7:0] OP_ER_S   = 8'h20;
    localparam logic [7:0] OP_ER_M   = 8'h52;
    localparam logic [7:0] OP_ER_SEC = 8'hD8;
    localparam logic [7:0] OP_ID     = 8'h9F;
    localparam logic [7:0] OP_BULK   = 8'hC7;

endpackage

// File: rtl/nor_store.sv
// Byte array of the flash model. It has a combinational read port at addr,
// a one-byte program port (clear-only or overwrite) and a single-cycle
// erase of an aligned power-of-two region. Assumes pr_go and er_go are
// never high together.
module nor_store #(
    parameter int ADDR_W    = 10,
    parameter int SMALL_LG  = 6,
    parameter int MID_LG    = 7,
    parameter int SECT_LG   = 8,
    parameter bit WRITE_ONE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              pr_go,
    input  logic [7:0]        pr_data,
    input  logic              er_go,
    input  nor_pkg::er_kind_t er_kind,
    output logic [7:0]        rd_data
);
    import nor_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0]        mem [DEPTH];
    logic [ADDR_W-1:0] keep_mask;

    // Address bits that must match for a byte to lie in the erase region.
    always_comb begin
        unique case (er_kind)
            ER_SMALL: keep_mask = {ADDR_W{1'b1}} << SMALL_LG;
            ER_MID:   keep_mask = {ADDR_W{1'b1}} << MID_LG;
            ER_SECT:  keep_mask = {ADDR_W{1'b1}} << SECT_LG;
            default:  keep_mask = '0;
        endcase
    end

    // Array update: reset fill, region erase, or single-byte program.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                mem[i] <= 8'hFF;
            end else if (er_go && (((ADDR_W'(i)) ^ addr) & keep_mask) == '0) begin
                mem[i] <= 8'hFF;
            end else if (pr_go && addr == ADDR_W'(i)) begin
                mem[i] <= WRITE_ONE ? pr_data : (mem[i] & pr_data);
            end
        end
    end

    assign rd_data = mem[addr];

endmodule

// File: rtl/nor_cmd_fsm.sv
// Command state machine. It decodes opcodes, shifts in address bytes,
// keeps the write-enable latch, the response buffer and the capability
// error flag, and registers one response byte per strobe. Assumes rd_data
// is the array byte at addr within the same cycle.
module nor_cmd_fsm #(
    parameter int          ADDR_W    = 10,
    parameter logic [23:0] JEDEC_ID  = 24'h3B6015,
    parameter logic [15:0] EXT_ID    = 16'h2A01,
    parameter bit          CAP_SMALL = 1'b1,
    parameter bit          CAP_MID   = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                rx_valid,
    input  logic [7:0]          rx_byte,
    input  logic [7:0]          rd_data,
    output logic [7:0]          tx_byte,
    output nor_pkg::eng_state_t cur_state,
    output logic                wel,
    output logic [ADDR_W-1:0]   addr,
    output logic                pr_go,
    output logic                er_go,
    output nor_pkg::er_kind_t   er_kind,
    output logic                cap_err
);
    import nor_pkg::*;

    localparam logic [2:0] ID_LEN = (EXT_ID != 16'h0) ? 3'd5 : 3'd3;

    logic [7:0]        cmd;
    logic [2:0]        cnt, need, pos, blen;
    logic [7:0]        rbuf [5];
    logic [ADDR_W+7:0] shifted;
    logic [ADDR_W-1:0] next_addr;
    er_kind_t          cmd_kind;
    logic              cmd_cap_ok;
    logic              strobe;

    assign strobe    = rx_valid && !cs_n;
    assign shifted   = {addr, rx_byte};
    assign next_addr = shifted[ADDR_W-1:0];
    assign pr_go     = strobe && cur_state == ST_PROG && wel;

    // Region kind and legality of the pending erase opcode.
    always_comb begin
        unique case (cmd)
            OP_ER_S: begin cmd_kind = ER_SMALL; cmd_cap_ok = CAP_SMALL; end
            OP_ER_M: begin cmd_kind = ER_MID;   cmd_cap_ok = CAP_MID;   end
            default: begin cmd_kind = ER_SECT;  cmd_cap_ok = 1'b1;      end
        endcase
    end

    // Main engine: frame abort, opcode decode, address collection, data phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_state <= ST_IDLE;
            cmd       <= OP_NOP;
            cnt       <= '0;
            need      <= '0;
            pos       <= '0;
            blen      <= '0;
            addr      <= '0;
            wel       <= 1'b0;
            er_go     <= 1'b0;
            er_kind   <= ER_ALL;
            cap_err   <= 1'b0;
            tx_byte   <= 8'h00;
            for (int k = 0; k < 5; k++) rbuf[k] <= 8'h00;
        end else begin
            er_go <= 1'b0;
            if (cs_n) begin
                cur_state <= ST_IDLE;
                cnt       <= '0;
                pos       <= '0;
            end else if (rx_valid) begin
                unique case (cur_state)
                    ST_IDLE: begin
                        tx_byte <= 8'h00;
                        cmd     <= rx_byte;
                        cnt     <= '0;
                        pos     <= '0;
                        case (rx_byte)
                            OP_PROG, OP_READ, OP_ER_S, OP_ER_M, OP_ER_SEC: begin
                                need      <= 3'd3;
                                cur_state <= ST_ADDR;
                            end
                            OP_FREAD: begin
                                need      <= 3'd4;
                                cur_state <= ST_ADDR;
                            end
                            OP_WREN:  wel <= 1'b1;
                            OP_WRDIS: wel <= 1'b0;
                            OP_STAT: begin
                                rbuf[0]   <= {6'b0, wel, 1'b0};
                                blen      <= 3'd1;
                                cur_state <= ST_RESP;
                            end
                            OP_ID: begin
                                rbuf[0]   <= JEDEC_ID[23:16];
                                rbuf[1]   <= JEDEC_ID[15:8];
                                rbuf[2]   <= JEDEC_ID[7:0];
                                rbuf[3]   <= EXT_ID[15:8];
                                rbuf[4]   <= EXT_ID[7:0];
                                blen      <= ID_LEN;
                                cur_state <= ST_RESP;
                            end
                            OP_BULK: begin
                                er_kind <= ER_ALL;
                                er_go   <= wel;
                            end
                            default: ;
                        endcase
                    end
                    ST_ADDR: begin
                        tx_byte <= 8'h00;
                        if (cnt < 3'd3) addr <= next_addr;
                        cnt <= cnt + 3'd1;
                        if (cnt + 3'd1 == need) begin
                            if (cmd == OP_PROG) begin
                                cur_state <= ST_PROG;
                            end else if (cmd == OP_READ || cmd == OP_FREAD) begin
                                cur_state <= ST_READ;
                            end else begin
                                cur_state <= ST_IDLE;
                                er_kind   <= cmd_kind;
                                if (!cmd_cap_ok) cap_err <= 1'b1;
                                else             er_go   <= wel;
                            end
                        end
                    end
                    ST_PROG: begin
                        tx_byte <= 8'h00;
                        addr    <= addr + 1'b1;
                    end
                    ST_READ: begin
                        tx_byte <= rd_data;
                        addr    <= addr + 1'b1;
                    end
                    ST_RESP: begin
                        tx_byte <= rbuf[pos];
                        if (pos + 3'd1 == blen) begin
                            pos       <= '0;
                            cur_state <= ST_IDLE;
                        end else begin
                            pos <= pos + 3'd1;
                        end
                    end
                    default: cur_state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/nor_flash_engine.sv
// Top of the serial NOR command engine. It joins the command state machine
// to the byte array. Assumes all byte counts are powers of two, that the
// device is at most 16 MiB, and that strobes come from an SPI shifter.
module nor_flash_engine #(
    parameter int          SECTOR_BYTES      = 256,
    parameter int          NUM_SECTORS       = 4,
    parameter int          ERASE_SMALL_BYTES = 64,
    parameter int          ERASE_MID_BYTES   = 128,
    parameter logic [23:0] JEDEC_ID          = 24'h3B6015,
    parameter logic [15:0] EXT_ID            = 16'h2A01,
    parameter bit          CAP_SMALL         = 1'b1,
    parameter bit          CAP_MID           = 1'b1,
    parameter bit          WRITE_ONE         = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    output logic [7:0] tx_byte,
    output logic       cap_err
);
    import nor_pkg::*;

    localparam int DEV_BYTES = SECTOR_BYTES * NUM_SECTORS;
    localparam int ADDR_W    = $clog2(DEV_BYTES);
    localparam int SECT_LG   = $clog2(SECTOR_BYTES);
    localparam int SMALL_LG  = $clog2(ERASE_SMALL_BYTES);
    localparam int MID_LG    = $clog2(ERASE_MID_BYTES);

    eng_state_t        cur_state;
    logic              wel;
    logic [ADDR_W-1:0] addr;
    logic              pr_go;
    logic              er_go;
    er_kind_t          er_kind;
    logic [7:0]        rd_data;

    nor_cmd_fsm #(
        .ADDR_W   (ADDR_W),
        .JEDEC_ID (JEDEC_ID),
        .EXT_ID   (EXT_ID),
        .CAP_SMALL(CAP_SMALL),
        .CAP_MID  (CAP_MID)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .rd_data  (rd_data),
        .tx_byte  (tx_byte),
        .cur_state(cur_state),
        .wel      (wel),
        .addr     (addr),
        .pr_go    (pr_go),
        .er_go    (er_go),
        .er_kind  (er_kind),
        .cap_err  (cap_err)
    );

    nor_store #(
        .ADDR_W   (ADDR_W),
        .SMALL_LG (SMALL_LG),
        .MID_LG   (MID_LG),
        .SECT_LG  (SECT_LG),
        .WRITE_ONE(WRITE_ONE)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .pr_go  (pr_go),
        .pr_data(rx_byte),
        .er_go  (er_go),
        .er_kind(er_kind),
        .rd_data(rd_data)
    );

endmodule

// File: rtl/nor_flash_checker.sv
// Temporal checks on the command engine's ports and the signals passed
// between its state machine and its array. Bound into every instance.
module nor_flash_checker (
    input logic                clk,
    input logic                rst_n,
    input logic                cs_n,
    input logic                rx_valid,
    input logic [7:0]          rx_byte,
    input logic [7:0]          tx_byte,
    input logic                cap_err,
    input nor_pkg::eng_state_t cur_state,
    input logic                wel,
    input logic                pr_go,
    input logic                er_go
);
    import nor_pkg::*;

    logic strobe;
    assign strobe = rx_valid && !cs_n;

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(tx_byte)); // R13
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cap_err |=> cap_err); // R8
    AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> cur_state == ST_IDLE); // R11
    AST_WEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && cur_state == ST_IDLE && rx_byte == OP_WREN) |=> wel); // R2
    AST_WEL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && cur_state == ST_IDLE && rx_byte == OP_WRDIS) |=> !wel); // R2
    AST_PROG_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        pr_go |-> wel); // R6
    AST_ERASE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        er_go |-> wel); // R7
    AST_ONE_ARRAY_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(er_go && pr_go)); // R7
    AST_PROG_TX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && cur_state == ST_PROG) |=> tx_byte == 8'h00); // R12

endmodule

bind nor_flash_engine nor_flash_checker u_chk (.*);

// File: tb/tb_nor_flash_engine.sv
module tb_nor_flash_engine;
    localparam int          CLK_PERIOD = 10;
    localparam int          DEV        = 1024;
    localparam logic [23:0] ID_A       = 24'h3B6015;
    localparam logic [15:0] EXT_A      = 16'h2A01;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic [7:0] tx_a, tx_b;
    logic       err_a, err_b;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 1'b0;

    logic [7:0] ma [DEV];
    logic [7:0] mb [DEV];
    bit         wel_m = 1'b0;
    bit         err_bm = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_flash_engine #(.JEDEC_ID(ID_A), .EXT_ID(EXT_A)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_byte(tx_a), .cap_err(err_a));

    nor_flash_engine #(.JEDEC_ID(ID_A), .EXT_ID(16'h0), .CAP_SMALL(1'b0),
                       .CAP_MID(1'b0), .WRITE_ONE(1'b1)) dut_alt (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_byte(tx_b), .cap_err(err_b));

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] ra, output logic [7:0] rb);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        ra = tx_a;
        rb = tx_b;
        rx_valid = 1'b0;
    endtask

    task automatic begin_f();
        @(negedge clk);
        cs_n = 1'b0;
    endtask

    task automatic end_f();
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic simple_op(input logic [7:0] op);
        logic [7:0] a, b;
        begin_f();
        xfer(op, a, b);
        end_f();
        if (op == 8'h06) wel_m = 1'b1;
        if (op == 8'h04) wel_m = 1'b0;
    endtask

    task automatic send_addr(input int addr, input string tag);
        logic [7:0] a, b;
        xfer(8'(addr >> 16), a, b);
        xfer(8'(addr >> 8), a, b);
        xfer(8'(addr), a, b);
        chk(tag, a, 8'h00);
    endtask

    task automatic status_chk(input string tag);
        logic [7:0] a, b;
        begin_f();
        xfer(8'h05, a, b);
        xfer(8'h00, a, b);
        end_f();
        chk(tag, a, {6'b0, wel_m, 1'b0});
        chk(tag, b, {6'b0, wel_m, 1'b0});
    endtask

    task automatic do_read(input int addr, input int n, input bit fast, input string tag);
        logic [7:0] a, b;
        begin_f();
        xfer(fast ? 8'h0B : 8'h03, a, b);
        send_addr(addr, "R12 addr byte");
        if (fast) xfer(8'($urandom), a, b);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, a, b);
            chk(tag, a, ma[(addr + i) % DEV]);
            chk(tag, b, mb[(addr + i) % DEV]);
        end
        end_f();
    endtask

    task automatic do_prog(input int addr, input int n);
        logic [7:0] a, b, d;
        begin_f();
        xfer(8'h02, a, b);
        send_addr(addr, "R12 addr byte");
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            xfer(d, a, b);
            if (wel_m) begin
                ma[(addr + i) % DEV] = ma[(addr + i) % DEV] & d;
                mb[(addr + i) % DEV] = d;
            end
        end
        end_f();
    endtask

    task automatic do_erase(input logic [7:0] op, input int addr);
        logic [7:0] a, b;
        int sa, sb;
        case (op)
            8'h20:   begin sa = 64;  sb = 0;   end
            8'h52:   begin sa = 128; sb = 0;   end
            8'hD8:   begin sa = 256; sb = 256; end
            default: begin sa = DEV; sb = DEV; end
        endcase
        begin_f();
        xfer(op, a, b);
        if (op != 8'hC7) send_addr(addr, "R12 addr byte");
        end_f();
        if (sb == 0) err_bm = 1'b1;
        if (wel_m) begin
            for (int i = 0; i < DEV; i++) begin
                if (i / sa == addr / sa) ma[i] = 8'hFF;
                if (sb != 0 && i / sb == addr / sb) mb[i] = 8'hFF;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] a, b, hold;
        int seed;
        seed = $urandom(32'h5EED);
        for (int i = 0; i < DEV; i++) begin ma[i] = 8'hFF; mb[i] = 8'hFF; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 tx", tx_a, 8'h00);
        chk("R1 err", {7'b0, err_a}, 8'h00);
        chk("R1 err alt", {7'b0, err_b}, 8'h00);
        status_chk("R1 R2 status after reset");
        do_read(0, 4, 1'b0, "R1 R3 erased read");

        // R6: program without write enable
        do_prog(16, 4);
        do_read(16, 4, 1'b0, "R6 no-wel program");

        // R2 R5: enable, program, program again
        simple_op(8'h06);
        status_chk("R2 status wel set");
        do_prog(16, 8);
        do_read(16, 8, 1'b0, "R5 program");
        do_prog(16, 8);
        do_read(16, 8, 1'b0, "R5 reprogram");
        simple_op(8'h04);
        status_chk("R2 status wel clear");
        simple_op(8'h06);

        // R3 R5: wrap at device end
        do_prog(DEV - 3, 6);
        do_read(DEV - 2, 5, 1'b0, "R3 wrap");
        do_read(4 * DEV + 16, 2, 1'b0, "R3 high bits dropped");

        // R4: fast read with dummy byte
        do_read(16, 8, 1'b1, "R4 fast read");

        // R13: response holds between strobes
        begin_f();
        xfer(8'h03, a, b);
        send_addr(17, "R12 addr byte");
        xfer(8'h00, a, b);
        hold = a;
        repeat (4) @(negedge clk);
        chk("R13 hold", tx_a, hold);
        chk("R13 value", hold, ma[17]);
        end_f();

        // R7 R8: sub-sector erase, capability error on alt
        do_erase(8'h20, 5);
        do_read(0, 80, 1'b0, "R7 R8 small erase");
        chk("R8 err dut", {7'b0, err_a}, 8'h00);
        chk("R8 err alt", {7'b0, err_b}, {7'b0, err_bm});
        do_prog(512, 16);
        do_prog(640, 16);
        simple_op(8'h04);
        do_erase(8'hD8, 520);
        do_read(512, 16, 1'b0, "R7 erase without wel");
        simple_op(8'h06);
        do_erase(8'h52, 650);
        do_read(512, 160, 1'b0, "R7 mid erase");
        do_erase(8'hD8, 520);
        do_read(512, 160, 1'b0, "R7 sector erase");
        chk("R8 sticky", {7'b0, err_b}, 8'h01);

        // R9: bulk erase
        do_prog(100, 8);
        simple_op(8'h04);
        do_erase(8'hC7, 0);
        do_read(100, 8, 1'b0, "R9 bulk without wel");
        simple_op(8'h06);
        do_erase(8'hC7, 0);
        do_read(0, DEV, 1'b0, "R9 bulk erase");

        // R10: identification then next opcode
        begin_f();
        xfer(8'h9F, a, b);
        chk("R12 opcode tx", a, 8'h00);
        xfer(8'h00, a, b); chk("R10 id0", a, ID_A[23:16]); chk("R10 id0 alt", b, ID_A[23:16]);
        xfer(8'h00, a, b); chk("R10 id1", a, ID_A[15:8]);  chk("R10 id1 alt", b, ID_A[15:8]);
        xfer(8'h00, a, b); chk("R10 id2", a, ID_A[7:0]);   chk("R10 id2 alt", b, ID_A[7:0]);
        xfer(8'h00, a, b); chk("R10 ext hi", a, EXT_A[15:8]); chk("R10 R12 alt nop", b, 8'h00);
        xfer(8'h00, a, b); chk("R10 ext lo", a, EXT_A[7:0]);  chk("R10 R12 alt nop", b, 8'h00);
        xfer(8'h05, a, b);
        xfer(8'h00, a, b);
        chk("R10 idle after id", a, 8'h02);
        chk("R10 idle after id alt", b, 8'h02);
        end_f();

        // R11: abort mid-address, strobe while deselected
        begin_f();
        xfer(8'h03, a, b);
        xfer(8'h00, a, b);
        xfer(8'h00, a, b);
        end_f();
        begin_f();
        xfer(8'h05, a, b);
        xfer(8'h00, a, b);
        chk("R11 abort resumes decode", a, 8'h02);
        end_f();
        simple_op(8'h04);
        xfer(8'h06, a, b);
        status_chk("R11 deselected strobe ignored");

        // R12: unknown and no-op opcodes
        begin_f();
        xfer(8'hA5, a, b); chk("R12 unknown", a, 8'h00);
        xfer(8'h00, a, b); chk("R12 nop", a, 8'h00);
        xfer(8'h05, a, b);
        xfer(8'h00, a, b); chk("R12 decode after unknown", a, 8'h00);
        end_f();

        // Random mix: R3 R5 R6 R7
        for (int it = 0; it < 60; it++) begin
            int addr, op;
            addr = int'($urandom % DEV);
            op = int'($urandom % 6);
            case (op)
                0: simple_op(8'h06);
                1: simple_op(8'h04);
                2, 3: do_prog(addr, 1 + int'($urandom % 8));
                4: do_erase(8'hD8, addr);
                default: do_read(addr, 1 + int'($urandom % 8), 1'($urandom), "R3 R4 random read");
            endcase
        end
        do_read(0, DEV, 1'b0, "R5 R6 R7 final array");
        chk("R8 final err alt", {7'b0, err_b}, {7'b0, err_bm});
        finish_run();
    end
endmodule